// File: doc/BRIEF.md
# Fully Associative Multi-Page-Size TLB

This block is a first-level translation cache that holds up to 48 virtual-to-physical mappings in one fully associative array. Each entry can have its own page size, from 4 KiB up to 32 MiB. Each entry is qualified by an address space identifier, a global flag and a virtual machine identifier. Because of these qualifiers, a change of process or of guest needs no flush.

A lookup presents a 48-bit virtual address together with the current ASID and VMID. One cycle later the block returns either a hit, with a 40-bit physical address and the entry's attribute byte, or a miss. On a miss the block raises a request toward the second-level TLB and stops accepting lookups. It waits until a refill arrives whose page covers the missed address. Refills and invalidate commands are accepted in any cycle, and each takes effect in a single cycle.

Top module: `fa_tlb`

## Requirements
- R1: Any of the 48 slots can hold any mapping, and 48 mappings with distinct pages can all be resident and hit at the same time.
- R2: The page size code `fillSize` selects the number of untranslated offset bits: 0 means 12 bits (4 KiB), 1 means 14 (16 KiB), 2 means 16 (64 KiB), 3 means 21 (2 MiB) and 4 means 25 (32 MiB). The address comparison ignores the offset bits. A lookup at offset size-1 of a page hits, and a lookup at offset size misses.
- R3: On a hit, `rspPa` holds the entry's frame bits above the offset and the request's own address bits below it. On a miss, `rspPa` and `rspAttr` are zero.
- R4: A global entry matches any request ASID. A non-global entry matches only when its ASID equals the request ASID.
- R5: A hit also requires the entry's VMID to equal the request VMID.
- R6: When `lkValid` is high and `lkReady` is high, the lookup is accepted. `rspValid` is then high for exactly the following cycle, with the result.
- R7: If several entries match, the result comes from the lowest-index entry.
- R8: A refill goes to the lowest-index invalid slot. If no slot is invalid, it goes to a round-robin pointer. The pointer starts at 0 and advances by one, wrapping at 48, on every refill.
- R9: `invOp` code 0 invalidates every entry in one cycle. Code 3 changes nothing. A refill in the same cycle as an invalidate still lands.
- R10: `invOp` code 1 invalidates every non-global entry whose ASID equals `invAsid`. Global entries stay valid.
- R11: `invOp` code 2 invalidates every entry whose VMID equals `invVmid`.
- R12: A miss drives `missReq` high and `lkReady` low from the cycle the miss response appears, and `missVa` holds the missed address. Lookups offered meanwhile get no response. Both outputs return one cycle after a refill whose page, masked at the refill's own size, contains `missVa`. A refill of any other page leaves them unchanged.
- R13: After reset no entry is valid, `rspValid` and `missReq` are low and `lkReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lkValid | input | 1 | Lookup request |
| lkReady | output | 1 | Lookup can be accepted (no miss pending) |
| lkVa | input | 48 | Lookup virtual address |
| lkAsid | input | 16 | Current address space identifier |
| lkVmid | input | 16 | Current virtual machine identifier |
| rspValid | output | 1 | Result valid, one cycle after acceptance |
| rspHit | output | 1 | Lookup hit |
| rspPa | output | 40 | Translated physical address |
| rspAttr | output | 8 | Attributes of the hitting entry |
| missReq | output | 1 | Request toward the second-level TLB is pending |
| missVa | output | 48 | Virtual address of the pending miss |
| missAsid | output | 16 | ASID of the pending miss |
| missVmid | output | 16 | VMID of the pending miss |
| fillValid | input | 1 | Refill write |
| fillVa | input | 48 | Refill virtual address |
| fillPa | input | 40 | Refill physical frame address |
| fillSize | input | 3 | Refill page size code |
| fillAsid | input | 16 | Refill ASID |
| fillVmid | input | 16 | Refill VMID |
| fillGlobal | input | 1 | Refill global flag |
| fillAttr | input | 8 | Refill attributes |
| invValid | input | 1 | Invalidate command |
| invOp | input | 2 | Invalidate kind: 0 all, 1 by ASID, 2 by VMID, 3 none |
| invAsid | input | 16 | ASID for invalidate by ASID |
| invVmid | input | 16 | VMID for invalidate by VMID |

## Verification
Some faults leave a slot valid when it should be cleared, or let it keep a stale size or qualifier. These show up only on the first later lookup that touches that slot, as a wrong hit, a wrong frame or a spurious miss. The bench therefore follows every refill and invalidate with lookups that probe the affected pages. A wrong victim choice is worse, because it stays hidden until the evicted page is looked up again, possibly dozens of refills later. The bench keeps a full model of slot placement so that every later lookup exposes it. A stuck pending state shows at once: `lkReady` stays low and the next response never appears.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_ASID = 2'd1,
    INV_VMID = 2'd2,
    INV_NONE = 2'd3
  } invOpE;

  typedef struct packed {
    logic lkAccept;
    logic fillWrite;
    logic invAll;
    logic invAsid;
    logic invVmid;
  } tlbStrobesT;

  function automatic int pageOffBits(input logic [2:0] sizeCode);
    case (sizeCode)
      3'd0:    return 12;
      3'd1:    return 14;
      3'd2:    return 16;
      3'd3:    return 21;
      3'd4:    return 25;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int N      = 48,
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int ASID_W = 16,
  parameter int VMID_W = 16,
  parameter int ATTR_W = 8,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobesT        strobes,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VMID_W-1:0] lkVmid,
  input  logic [VA_W-1:0]   fillVa,
  input  logic [PA_W-1:0]   fillPa,
  input  logic [2:0]        fillSize,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [VMID_W-1:0] fillVmid,
  input  logic              fillGlobal,
  input  logic [ATTR_W-1:0] fillAttr,
  input  logic [ASID_W-1:0] invAsidVal,
  input  logic [VMID_W-1:0] invVmidVal,
  output logic [N-1:0]      validVec,
  output logic              lookupHit,
  output logic              fillHitsMiss,
  output logic              rspValid,
  output logic              rspHit,
  output logic [PA_W-1:0]   rspPa,
  output logic [ATTR_W-1:0] rspAttr,
  output logic [VA_W-1:0]   missVa,
  output logic [ASID_W-1:0] missAsid,
  output logic [VMID_W-1:0] missVmid
);

  logic [N-1:0]      entValid;
  logic [VA_W-1:0]   entVa     [N];
  logic [PA_W-1:0]   entPa     [N];
  logic [2:0]        entSize   [N];
  logic [ASID_W-1:0] entAsid   [N];
  logic [VMID_W-1:0] entVmid   [N];
  logic              entGlobal [N];
  logic [ATTR_W-1:0] entAttr   [N];

  logic [N-1:0]      matchVec;
  logic [N-1:0]      killVec;
  logic [IDX_W-1:0]  selIdx;
  logic [PA_W-1:0]   offMask;
  logic [PA_W-1:0]   composedPa;

  function automatic logic [VA_W-1:0] vaPageMask(input logic [2:0] sizeCode);
    logic [VA_W-1:0] ones;
    ones = '1;
    return ones << pageOffBits(sizeCode);
  endfunction

  function automatic logic [PA_W-1:0] paOffsetMask(input logic [2:0] sizeCode);
    logic [PA_W-1:0] ones;
    ones = '1;
    return ~(ones << pageOffBits(sizeCode));
  endfunction

  // Per-entry comparators and invalidate selectors
  for (genvar g = 0; g < N; g++) begin : g_entry
    logic [VA_W-1:0] pageMask;
    logic            vaEq;
    logic            ctxEq;
    assign pageMask    = vaPageMask(entSize[g]);
    assign vaEq        = ((lkVa ^ entVa[g]) & pageMask) == '0;
    assign ctxEq       = (entGlobal[g] || (entAsid[g] == lkAsid)) && (entVmid[g] == lkVmid);
    assign matchVec[g] = entValid[g] && vaEq && ctxEq;
    assign killVec[g]  = strobes.invAll
                      || (strobes.invAsid && !entGlobal[g] && (entAsid[g] == invAsidVal))
                      || (strobes.invVmid && (entVmid[g] == invVmidVal));
  end

  // Lowest index wins on multiple matches
  always_comb begin
    selIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign lookupHit  = |matchVec;
  assign offMask    = paOffsetMask(entSize[selIdx]);
  assign composedPa = (entPa[selIdx] & ~offMask) | (lkVa[PA_W-1:0] & offMask);
  assign validVec   = entValid;

  assign fillHitsMiss = ((fillVa ^ missVa) & vaPageMask(fillSize)) == '0;

  // Valid bits: invalidate first, refill slot wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (killVec[i]) entValid[i] <= 1'b0;
      end
      if (strobes.fillWrite) entValid[fillIdx] <= 1'b1;
    end
  end

  // Entry payload
  always_ff @(posedge clk) begin
    if (strobes.fillWrite) begin
      entVa[fillIdx]     <= fillVa;
      entPa[fillIdx]     <= fillPa;
      entSize[fillIdx]   <= fillSize;
      entAsid[fillIdx]   <= fillAsid;
      entVmid[fillIdx]   <= fillVmid;
      entGlobal[fillIdx] <= fillGlobal;
      entAttr[fillIdx]   <= fillAttr;
    end
  end

  // Registered response and miss context
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspPa    <= '0;
      rspAttr  <= '0;
      missVa   <= '0;
      missAsid <= '0;
      missVmid <= '0;
    end else begin
      rspValid <= strobes.lkAccept;
      if (strobes.lkAccept) begin
        rspHit   <= lookupHit;
        rspPa    <= lookupHit ? composedPa : '0;
        rspAttr  <= lookupHit ? entAttr[selIdx] : '0;
        missVa   <= lkVa;
        missAsid <= lkAsid;
        missVmid <= lkVmid;
      end
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lkAccept |=> rspValid);  // R6

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.lkAccept |=> !rspValid);  // R6

  AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.invAll && !strobes.fillWrite) |=> (entValid == '0));  // R9

  AST_MISS_ZERO_PA: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspPa == '0));  // R3

endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int N     = 48,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic             lookupHit,
  input  logic             fillValid,
  input  logic             fillHitsMiss,
  input  logic             invValid,
  input  logic [1:0]       invOp,
  input  logic [N-1:0]     validVec,
  output tlbStrobesT       strobes,
  output logic [IDX_W-1:0] fillIdx,
  output logic             pending,
  output logic             lkReady
);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic             hasFree;

  always_comb begin
    freeIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign hasFree = ~&validVec;
  assign fillIdx = hasFree ? freeIdx : rrPtr;
  assign lkReady = !pending;

  assign strobes.lkAccept  = lkValid && !pending;
  assign strobes.fillWrite = fillValid;
  assign strobes.invAll    = invValid && (invOpE'(invOp) == INV_ALL);
  assign strobes.invAsid   = invValid && (invOpE'(invOp) == INV_ASID);
  assign strobes.invVmid   = invValid && (invOpE'(invOp) == INV_VMID);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (pending && fillValid && fillHitsMiss) begin
      pending <= 1'b0;
    end else if (strobes.lkAccept && !lookupHit) begin
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (fillValid) begin
      rrPtr <= (rrPtr == IDX_W'(N - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fillWrite |=> validVec[$past(fillIdx)]);  // R8

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !(fillValid && fillHitsMiss)) |=> pending);  // R12

endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
  import tlb_pkg::*;
#(
  parameter int N      = 48,
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int ASID_W = 16,
  parameter int VMID_W = 16,
  parameter int ATTR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  output logic              lkReady,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VMID_W-1:0] lkVmid,
  output logic              rspValid,
  output logic              rspHit,
  output logic [PA_W-1:0]   rspPa,
  output logic [ATTR_W-1:0] rspAttr,
  output logic              missReq,
  output logic [VA_W-1:0]   missVa,
  output logic [ASID_W-1:0] missAsid,
  output logic [VMID_W-1:0] missVmid,
  input  logic              fillValid,
  input  logic [VA_W-1:0]   fillVa,
  input  logic [PA_W-1:0]   fillPa,
  input  logic [2:0]        fillSize,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [VMID_W-1:0] fillVmid,
  input  logic              fillGlobal,
  input  logic [ATTR_W-1:0] fillAttr,
  input  logic              invValid,
  input  logic [1:0]        invOp,
  input  logic [ASID_W-1:0] invAsid,
  input  logic [VMID_W-1:0] invVmid
);

  localparam int IDX_W = $clog2(N);

  tlbStrobesT       strobes;
  logic [IDX_W-1:0] fillIdx;
  logic [N-1:0]     validVec;
  logic             lookupHit;
  logic             fillHitsMiss;
  logic             pending;

  tlb_control #(.N(N), .IDX_W(IDX_W)) i_control (
    .clk          (clk),
    .rstN         (rstN),
    .lkValid      (lkValid),
    .lookupHit    (lookupHit),
    .fillValid    (fillValid),
    .fillHitsMiss (fillHitsMiss),
    .invValid     (invValid),
    .invOp        (invOp),
    .validVec     (validVec),
    .strobes      (strobes),
    .fillIdx      (fillIdx),
    .pending      (pending),
    .lkReady      (lkReady)
  );

  tlb_datapath #(
    .N(N), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W),
    .VMID_W(VMID_W), .ATTR_W(ATTR_W), .IDX_W(IDX_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .fillIdx      (fillIdx),
    .lkVa         (lkVa),
    .lkAsid       (lkAsid),
    .lkVmid       (lkVmid),
    .fillVa       (fillVa),
    .fillPa       (fillPa),
    .fillSize     (fillSize),
    .fillAsid     (fillAsid),
    .fillVmid     (fillVmid),
    .fillGlobal   (fillGlobal),
    .fillAttr     (fillAttr),
    .invAsidVal   (invAsid),
    .invVmidVal   (invVmid),
    .validVec     (validVec),
    .lookupHit    (lookupHit),
    .fillHitsMiss (fillHitsMiss),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspPa        (rspPa),
    .rspAttr      (rspAttr),
    .missVa       (missVa),
    .missAsid     (missAsid),
    .missVmid     (missVmid)
  );

  assign missReq = pending;

  AST_MISS_RAISES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> missReq);  // R12

  AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && lkValid) |=> !rspValid);  // R12

endmodule

// File: tb/test_fa_tlb.sv
module test_fa_tlb;

  localparam int N = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic        lkReady;
  logic [47:0] lkVa = '0;
  logic [15:0] lkAsid = '0;
  logic [15:0] lkVmid = '0;
  logic        rspValid;
  logic        rspHit;
  logic [39:0] rspPa;
  logic [7:0]  rspAttr;
  logic        missReq;
  logic [47:0] missVa;
  logic [15:0] missAsid;
  logic [15:0] missVmid;
  logic        fillValid = 1'b0;
  logic [47:0] fillVa = '0;
  logic [39:0] fillPa = '0;
  logic [2:0]  fillSize = '0;
  logic [15:0] fillAsid = '0;
  logic [15:0] fillVmid = '0;
  logic        fillGlobal = 1'b0;
  logic [7:0]  fillAttr = '0;
  logic        invValid = 1'b0;
  logic [1:0]  invOp = '0;
  logic [15:0] invAsid = '0;
  logic [15:0] invVmid = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference model
  bit          mValid [N];
  logic [47:0] mVa    [N];
  logic [39:0] mPa    [N];
  int          mSize  [N];
  logic [15:0] mAsid  [N];
  logic [15:0] mVmid  [N];
  bit          mGlb   [N];
  logic [7:0]  mAttr  [N];
  int          mRr = 0;

  always #4 clk = ~clk;

  fa_tlb i_fa_tlb (.*);

  function automatic int offBits(int sz);
    case (sz)
      0: return 12;
      1: return 14;
      2: return 16;
      3: return 21;
      default: return 25;
    endcase
  endfunction

  function automatic logic [47:0] pgMask(int sz);
    logic [47:0] ones = '1;
    return ones << offBits(sz);
  endfunction

  function automatic int mLookup(logic [47:0] va, logic [15:0] asid, logic [15:0] vmid);
    for (int i = 0; i < N; i++) begin
      if (mValid[i] && (((va ^ mVa[i]) & pgMask(mSize[i])) == '0)
          && (mGlb[i] || mAsid[i] == asid) && (mVmid[i] == vmid))
        return i;
    end
    return -1;
  endfunction

  function automatic logic [39:0] mPaOf(int i, logic [47:0] va);
    logic [39:0] ones = '1;
    logic [39:0] om;
    om = ~(ones << offBits(mSize[i]));
    return (mPa[i] & ~om) | (va[39:0] & om);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doFill(logic [47:0] va, logic [39:0] pa, int sz, logic [15:0] asid,
                        logic [15:0] vmid, bit glb, logic [7:0] attr);
    int v = -1;
    for (int i = N - 1; i >= 0; i--) if (!mValid[i]) v = i;
    if (v < 0) v = mRr;
    mRr = (mRr + 1) % N;
    mValid[v] = 1; mVa[v] = va; mPa[v] = pa; mSize[v] = sz;
    mAsid[v] = asid; mVmid[v] = vmid; mGlb[v] = glb; mAttr[v] = attr;
    fillValid = 1; fillVa = va; fillPa = pa; fillSize = 3'(sz);
    fillAsid = asid; fillVmid = vmid; fillGlobal = glb; fillAttr = attr;
    @(negedge clk);
    fillValid = 0;
  endtask

  task automatic doInv(int op, logic [15:0] asid, logic [15:0] vmid);
    for (int i = 0; i < N; i++) begin
      if (op == 0 || (op == 1 && !mGlb[i] && mAsid[i] == asid) || (op == 2 && mVmid[i] == vmid))
        mValid[i] = 0;
    end
    invValid = 1; invOp = 2'(op); invAsid = asid; invVmid = vmid;
    @(negedge clk);
    invValid = 0;
  endtask

  task automatic doLookup(logic [47:0] va, logic [15:0] asid, logic [15:0] vmid, string req);
    int e = mLookup(va, asid, vmid);
    lkValid = 1; lkVa = va; lkAsid = asid; lkVmid = vmid;
    @(negedge clk);
    lkValid = 0;
    chk(req, "rspValid", 64'(rspValid), 64'd1);
    if (e >= 0) begin
      chk(req, "rspHit", 64'(rspHit), 64'd1);
      chk(req, "rspPa", 64'(rspPa), 64'(mPaOf(e, va)));
      chk(req, "rspAttr", 64'(rspAttr), 64'(mAttr[e]));
    end else begin
      chk(req, "rspHit", 64'(rspHit), 64'd0);
      chk("R12", "missReq", 64'(missReq), 64'd1);
      chk("R12", "missVa", 64'(missVa), 64'(va));
      chk("R12", "lkReady", 64'(lkReady), 64'd0);
      doFill(va, {8'($urandom), 32'($urandom)}, 0, asid, vmid, 0, 8'h5A);
      chk("R12", "missReq cleared", 64'(missReq), 64'd0);
      chk("R12", "lkReady restored", 64'(lkReady), 64'd1);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < N; i++) mValid[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13", "rspValid", 64'(rspValid), 64'd0);
    chk("R13", "missReq", 64'(missReq), 64'd0);
    chk("R13", "lkReady", 64'(lkReady), 64'd1);

    // R12: miss, blocked lookups, non-matching refill, matching refill
    lkValid = 1; lkVa = 48'h0000_7000_0123; lkAsid = 16'd1; lkVmid = 16'd1;
    @(negedge clk);
    chk("R13", "empty array misses", 64'(rspHit), 64'd0);
    chk("R12", "missReq", 64'(missReq), 64'd1);
    @(negedge clk);
    lkValid = 0;
    chk("R12", "no rsp while pending", 64'(rspValid), 64'd0);
    doFill(48'h0000_7000_5000, 40'h00_0ABC_D000, 0, 16'd1, 16'd1, 0, 8'h11);
    chk("R12", "other page keeps pending", 64'(missReq), 64'd1);
    doFill(48'h0000_7000_0000, 40'h00_1234_5000, 0, 16'd1, 16'd1, 0, 8'h22);
    chk("R12", "covering refill clears", 64'(missReq), 64'd0);
    doLookup(48'h0000_7000_0ABC, 16'd1, 16'd1, "R3");

    // R2 page sizes
    for (int sz = 0; sz < 5; sz++) begin
      logic [47:0] base = 48'h1200_0000_0000 + (48'(sz) << 30);
      doFill(base, 40'hFF_FFFF_FFFF, sz, 16'd4, 16'(10 + sz), 0, 8'(sz));
      doLookup(base + (48'd1 << offBits(sz)) - 48'd1, 16'd4, 16'(10 + sz), "R2");
      doLookup(base + (48'd1 << offBits(sz)), 16'd4, 16'(10 + sz), "R2");
    end

    // R4 and R5 qualifiers
    doFill(48'h2000_0040_0000, 40'h00_AA00_0000, 3, 16'd1, 16'd2, 1, 8'h31);
    doFill(48'h2000_0080_0000, 40'h00_BB00_0000, 3, 16'd2, 16'd2, 0, 8'h32);
    doLookup(48'h2000_0041_2345, 16'd3, 16'd2, "R4");
    doLookup(48'h2000_0081_2345, 16'd2, 16'd2, "R4");
    doLookup(48'h2000_0082_2345, 16'd3, 16'd2, "R4");
    doLookup(48'h2000_0043_0000, 16'd1, 16'd3, "R5");

    // R7, R10, R8 placement and priority
    doInv(0, 16'd0, 16'd0);
    doFill(48'h4000_0000_0000, 40'h00_0011_1000, 0, 16'd5, 16'd1, 0, 8'h41);
    doFill(48'h4000_0000_0000, 40'h00_0220_0000, 3, 16'd5, 16'd1, 1, 8'h42);
    doLookup(48'h4000_0000_0123, 16'd5, 16'd1, "R7");
    doInv(1, 16'd5, 16'd0);
    doLookup(48'h4000_0000_0123, 16'd5, 16'd1, "R10");
    doFill(48'h4000_0000_0000, 40'h00_0033_3000, 0, 16'd5, 16'd1, 0, 8'h43);
    doLookup(48'h4000_0000_0456, 16'd5, 16'd1, "R7");

    // R11 by VMID, R9 no-op code
    doInv(3, 16'd5, 16'd1);
    doLookup(48'h4000_0000_0789, 16'd5, 16'd1, "R9");
    doInv(2, 16'd0, 16'd1);
    doLookup(48'h4000_0000_0789, 16'd5, 16'd1, "R11");

    // R1 full occupancy, R8 round-robin eviction
    doInv(0, 16'd0, 16'd0);
    for (int i = 0; i < N; i++)
      doFill(48'h5000_0000_0000 + (48'(i) << 12), 40'h00_8000_0000 + (40'(i) << 12), 0,
             16'd7, 16'd7, 0, 8'(i));
    for (int i = 0; i < N; i++)
      doLookup(48'h5000_0000_0010 + (48'(i) << 12), 16'd7, 16'd7, "R1");
    doFill(48'h5000_1000_0000, 40'h00_9000_0000, 0, 16'd7, 16'd7, 0, 8'hEE);
    for (int i = 0; i < 3; i++)
      doLookup(48'h5000_0000_0020 + (48'(i) << 12), 16'd7, 16'd7, "R8");
    doLookup(48'h5000_1000_0abc, 16'd7, 16'd7, "R8");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom_range(0, 99));
      logic [47:0] va = {21'h0ABCD, 2'($urandom_range(0, 3)), 25'($urandom)};
      logic [15:0] a = 16'($urandom_range(1, 2));
      logic [15:0] v = 16'($urandom_range(1, 2));
      if (op < 50) doLookup(va, a, v, "R7");
      else if (op < 88) doFill(va, {8'($urandom), 32'($urandom)}, int'($urandom_range(0, 4)),
                               a, v, bit'($urandom_range(0, 1)), 8'($urandom));
      else if (op < 96) doInv(int'($urandom_range(1, 2)), a, v);
      else doInv(0, 16'd0, 16'd0);
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule